// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block gathers single-cycle event strobes from the transmit, receive, DMA and statistics sections of a packet network controller. It latches them into an 8-bit cause register and drives one level-sensitive host interrupt request, gated by a 7-bit enable register. The host reaches both registers through a small synchronous port. Reads are combinational. A write to the cause register clears every bit written as 1. A write to the enable register replaces its contents.

Two event rules shape the cause bits. A receive error that arrives together with a receive DMA abort is dropped, and only the overwrite bit is recorded. In chained transmit mode, per-packet completions are only accumulated. The packet-sent cause is raised once, when the chain finishes, and only if some packet in the chain succeeded or the chain held no packets.

The early-receive warning is computed inside the block by comparing the live frame byte count against a limit input. The counter overflow cause is derived from the rising edge of any error counter's top bit.

Top module: `netirq_agg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the cause register reads 0x80, the enable register reads 0x00 and irq is 0.
- R2: A host write to address 0 clears each cause bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: When a hardware event sets a cause bit in the same cycle that a host write clears it, the bit ends up 1.
- R4: Cause bits are set and readable whatever the enable register holds. irq is 1 exactly when some bit i in 0..6 is set in both the cause register and the enable register. Bit 7 never drives irq.
- R5: A halt_evt pulse sets cause bit 7 (stopped).
- R6: rx_abort_evt sets bit 4 (overwrite). rx_err_evt sets bit 2 (receive error) only when rx_abort_evt is low in the same cycle. An abort never clears an already set bit 2.
- R7: With tx_chain_mode low, tx_pkt_done with tx_pkt_ok sets bit 1. tx_pkt_done without tx_pkt_ok does not set bit 1. rx_good_evt sets bit 0, and tx_err_evt sets bit 3.
- R8: With tx_chain_mode high, tx_pkt_done never sets bit 1 before tx_chain_end. On tx_chain_end, bit 1 is set if any packet of the chain had tx_pkt_ok, counting one completing in that same cycle, or if the chain held no packets.
- R9: Bit 6 (early warning) is set in the cycle that rx_in_frame is high and rx_byte_cnt first becomes strictly greater than early_limit. It is set only once per crossing, and a count equal to the limit does not set it.
- R10: Bit 5 (counter overflow) is set when any bit of err_cnt_msb rises from 0 to 1. A bit that stays high does not set it again.
- R11: Address 1 holds the enable register. A write stores write-data bits 6..0, and a read returns them with bit 7 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_evt | input | 1 | Transmit and receive sections halted |
| rx_good_evt | input | 1 | Frame received without error |
| rx_err_evt | input | 1 | Frame received with error |
| rx_abort_evt | input | 1 | Receive DMA aborted for lack of buffers |
| tx_err_evt | input | 1 | Transmission failed |
| tx_pkt_done | input | 1 | One transmit packet completed |
| tx_pkt_ok | input | 1 | Qualifies tx_pkt_done as successful |
| tx_chain_mode | input | 1 | Defer packet-sent cause to chain end |
| tx_chain_end | input | 1 | Transmit chain fully processed |
| rx_in_frame | input | 1 | A frame is being received |
| rx_byte_cnt | input | LEN_W | Bytes received so far in the frame |
| early_limit | input | LEN_W | Early warning threshold |
| err_cnt_msb | input | CNT_N | Top bit of each error counter |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = cause register, 1 = enable register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| irq | output | 1 | Level interrupt request |

## Verification
A hardware set and a host clear can hit the same cause bit in one cycle. The bench provokes this by pulsing an event on the same clock edge that a write of 1 targets that bit, and then confirms that the bit still reads 1. It also clears a different bit on the same edge, to confirm that the clear half of the write was not lost. Likewise, a packet completion that coincides with the chain end is judged on whether its success flag counts.

// File: rtl/netirq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt aggregator: cause bit positions,
// reset value of the cause register and host address decode.
package netirq_pkg;
    localparam int ST_W   = 8;
    localparam int EN_W   = 7;
    localparam int B_STOP = 7;
    localparam int B_ERW  = 6;
    localparam int B_CNT  = 5;
    localparam int B_OVW  = 4;
    localparam int B_TXE  = 3;
    localparam int B_RXE  = 2;
    localparam int B_PTX  = 1;
    localparam int B_PRX  = 0;
    localparam logic [ST_W-1:0] ST_RESET = 8'h80;

    typedef enum logic {
        ADDR_CAUSE  = 1'b0,
        ADDR_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/netirq_txchain.sv
`timescale 1ns/1ps
// Packet-sent decision. Outside chain mode a successful completion
// raises ptx_set at once. In chain mode completions are accumulated
// and judged on chain_end.
// Assumes chain_mode is only changed between chains.
module netirq_txchain (
    input  logic clk,
    input  logic rst_n,
    input  logic chain_mode,
    input  logic pkt_done,
    input  logic pkt_ok,
    input  logic chain_end,
    output logic ptx_set
);
    logic any_ok_q;
    logic seen_q;
    logic done_ok;

    assign done_ok = pkt_done & pkt_ok;

    // Track whether the current chain saw any packet and any success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_ok_q <= 1'b0;
            seen_q   <= 1'b0;
        end else if (chain_end || !chain_mode) begin
            any_ok_q <= 1'b0;
            seen_q   <= 1'b0;
        end else if (pkt_done) begin
            seen_q   <= 1'b1;
            any_ok_q <= any_ok_q | pkt_ok;
        end
    end

    // Raise the packet-sent cause now or at the chain boundary.
    always_comb begin
        if (!chain_mode) begin
            ptx_set = done_ok;
        end else begin
            ptx_set = chain_end & (any_ok_q | done_ok | ~(seen_q | pkt_done));
        end
    end

    AST_NO_MIDCHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && !chain_end) |-> !ptx_set); // R8
endmodule

// File: rtl/netirq_events.sv
`timescale 1ns/1ps
// Turns raw controller strobes into a per-bit set vector for the cause
// register. Applies the abort rule, derives the early warning from a
// byte count compare and counter overflow from MSB rising edges.
// Assumes all strobes are synchronous to clk.
module netirq_events #(
    parameter int LEN_W = 11,
    parameter int CNT_N = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      halt_evt,
    input  logic                      rx_good_evt,
    input  logic                      rx_err_evt,
    input  logic                      rx_abort_evt,
    input  logic                      tx_err_evt,
    input  logic                      tx_pkt_done,
    input  logic                      tx_pkt_ok,
    input  logic                      tx_chain_mode,
    input  logic                      tx_chain_end,
    input  logic                      rx_in_frame,
    input  logic [LEN_W-1:0]          rx_byte_cnt,
    input  logic [LEN_W-1:0]          early_limit,
    input  logic [CNT_N-1:0]          err_cnt_msb,
    output logic [netirq_pkg::ST_W-1:0] set_vec
);
    import netirq_pkg::*;

    logic             exceed;
    logic             exceed_q;
    logic [CNT_N-1:0] msb_q;
    logic [CNT_N-1:0] msb_rise;
    logic             ptx_set;

    assign exceed = rx_in_frame && (rx_byte_cnt > early_limit);

    // Remember last cycle's threshold and counter MSB state for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exceed_q <= 1'b0;
            msb_q    <= '0;
        end else begin
            exceed_q <= exceed;
            msb_q    <= err_cnt_msb;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < CNT_N; gi++) begin : g_msb
            assign msb_rise[gi] = err_cnt_msb[gi] & ~msb_q[gi];
        end
    endgenerate

    netirq_txchain u_txchain (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_mode (tx_chain_mode),
        .pkt_done   (tx_pkt_done),
        .pkt_ok     (tx_pkt_ok),
        .chain_end  (tx_chain_end),
        .ptx_set    (ptx_set)
    );

    // Map every source onto its cause bit.
    always_comb begin
        set_vec         = '0;
        set_vec[B_STOP] = halt_evt;
        set_vec[B_ERW]  = exceed & ~exceed_q;
        set_vec[B_CNT]  = |msb_rise;
        set_vec[B_OVW]  = rx_abort_evt;
        set_vec[B_TXE]  = tx_err_evt;
        set_vec[B_RXE]  = rx_err_evt & ~rx_abort_evt;
        set_vec[B_PTX]  = ptx_set;
        set_vec[B_PRX]  = rx_good_evt;
    end

    AST_ERW_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        exceed |=> (exceed -> !set_vec[B_ERW])); // R9
endmodule

// File: rtl/netirq_status.sv
`timescale 1ns/1ps
// Cause register: sticky bits set by hardware, cleared by host
// write-one. A set in the same cycle as a clear wins.
module netirq_status #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = 8'h80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] st
);
    // Apply clears, then sets, on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RST_VAL;
        end else begin
            st <= (st & ~clr_vec) | set_vec;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((st & $past(set_vec)) == $past(set_vec))); // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((st & $past(clr_vec & ~set_vec)) == '0)); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> $stable(st)); // R2
endmodule

// File: rtl/netirq_regport.sv
`timescale 1ns/1ps
// Host register port: holds the enable register, turns cause-register
// writes into a clear vector and multiplexes the read data.
// Reads are combinational; writes take effect on the next edge.
module netirq_regport (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic                          host_addr,
    input  logic [netirq_pkg::ST_W-1:0]   host_wdata,
    input  logic [netirq_pkg::ST_W-1:0]   st,
    output logic [netirq_pkg::ST_W-1:0]   clr_vec,
    output logic [netirq_pkg::EN_W-1:0]   en,
    output logic [netirq_pkg::ST_W-1:0]   host_rdata
);
    import netirq_pkg::*;

    logic wr_cause;
    logic wr_en;

    assign wr_cause = host_wr && (host_addr == ADDR_CAUSE);
    assign wr_en    = host_wr && (host_addr == ADDR_ENABLE);
    assign clr_vec  = wr_cause ? host_wdata : '0;

    // Load the enable register on a host write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_en) begin
            en <= host_wdata[EN_W-1:0];
        end
    end

    // Select the register named by the address.
    always_comb begin
        if (host_addr == ADDR_ENABLE) begin
            host_rdata = {1'b0, en};
        end else begin
            host_rdata = st;
        end
    end

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en == $past(host_wdata[EN_W-1:0]))); // R11
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en)); // R11
endmodule

// File: rtl/netirq_agg.sv
`timescale 1ns/1ps
// Top of the interrupt aggregator: event conditioning, cause register,
// host port and the level interrupt request.
// Assumes a single clock domain and a synchronous active-low reset.
module netirq_agg #(
    parameter int LEN_W = 11,
    parameter int CNT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_evt,
    input  logic             rx_good_evt,
    input  logic             rx_err_evt,
    input  logic             rx_abort_evt,
    input  logic             tx_err_evt,
    input  logic             tx_pkt_done,
    input  logic             tx_pkt_ok,
    input  logic             tx_chain_mode,
    input  logic             tx_chain_end,
    input  logic             rx_in_frame,
    input  logic [LEN_W-1:0] rx_byte_cnt,
    input  logic [LEN_W-1:0] early_limit,
    input  logic [CNT_N-1:0] err_cnt_msb,
    input  logic             host_wr,
    input  logic             host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             irq
);
    import netirq_pkg::*;

    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] clr_vec;
    logic [ST_W-1:0] st;
    logic [EN_W-1:0] en;

    netirq_events #(.LEN_W(LEN_W), .CNT_N(CNT_N)) u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_evt      (halt_evt),
        .rx_good_evt   (rx_good_evt),
        .rx_err_evt    (rx_err_evt),
        .rx_abort_evt  (rx_abort_evt),
        .tx_err_evt    (tx_err_evt),
        .tx_pkt_done   (tx_pkt_done),
        .tx_pkt_ok     (tx_pkt_ok),
        .tx_chain_mode (tx_chain_mode),
        .tx_chain_end  (tx_chain_end),
        .rx_in_frame   (rx_in_frame),
        .rx_byte_cnt   (rx_byte_cnt),
        .early_limit   (early_limit),
        .err_cnt_msb   (err_cnt_msb),
        .set_vec       (set_vec)
    );

    netirq_status #(.W(ST_W), .RST_VAL(ST_RESET)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .st      (st)
    );

    netirq_regport u_regport (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .st         (st),
        .clr_vec    (clr_vec),
        .en         (en),
        .host_rdata (host_rdata)
    );

    // Request service while any enabled cause below the stopped bit is set.
    always_comb begin
        irq = |(st[EN_W-1:0] & en);
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (st == ST_RESET && en == '0 && !irq)); // R1
    AST_STOP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st[EN_W-1:0] == '0) |-> !irq); // R4
    AST_RXE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_evt && rx_abort_evt && !st[B_RXE]) |=> !st[B_RXE]); // R6
    AST_RXE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_abort_evt && st[B_RXE] && !clr_vec[B_RXE]) |=> st[B_RXE]); // R6
    AST_PTX_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st[B_PTX]) && $past(tx_chain_mode)) |-> $past(tx_chain_end)); // R8
    AST_HALT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_evt |=> st[B_STOP]); // R5
endmodule

// File: tb/netirq_agg_bench.sv
`timescale 1ns/1ps
module netirq_agg_bench;
    localparam int LEN_W = 11;
    localparam int CNT_N = 3;
    localparam logic [LEN_W-1:0] LIMIT = 11'd64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_evt = 0, rx_good_evt = 0, rx_err_evt = 0, rx_abort_evt = 0;
    logic tx_err_evt = 0, tx_pkt_done = 0, tx_pkt_ok = 0;
    logic tx_chain_mode = 0, tx_chain_end = 0, rx_in_frame = 0;
    logic [LEN_W-1:0] rx_byte_cnt = '0;
    logic [LEN_W-1:0] early_limit = LIMIT;
    logic [CNT_N-1:0] err_cnt_msb = '0;
    logic host_wr = 0, host_addr = 0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    netirq_agg #(.LEN_W(LEN_W), .CNT_N(CNT_N)) u_netirq_agg (
        .clk(clk), .rst_n(rst_n), .halt_evt(halt_evt), .rx_good_evt(rx_good_evt),
        .rx_err_evt(rx_err_evt), .rx_abort_evt(rx_abort_evt), .tx_err_evt(tx_err_evt),
        .tx_pkt_done(tx_pkt_done), .tx_pkt_ok(tx_pkt_ok), .tx_chain_mode(tx_chain_mode),
        .tx_chain_end(tx_chain_end), .rx_in_frame(rx_in_frame), .rx_byte_cnt(rx_byte_cnt),
        .early_limit(early_limit), .err_cnt_msb(err_cnt_msb), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    // Produce the stimulus that sets cause bit b (0..6) with no other side effect.
    task automatic set_bit(input int b);
        case (b)
            6: begin rx_in_frame = 1; rx_byte_cnt = LIMIT + 1; end
            5: err_cnt_msb = 3'b001;
            4: rx_abort_evt = 1;
            3: tx_err_evt = 1;
            2: rx_err_evt = 1;
            1: begin tx_pkt_done = 1; tx_pkt_ok = 1; end
            default: rx_good_evt = 1;
        endcase
        tick();
        rx_in_frame = 0; rx_byte_cnt = '0; err_cnt_msb = '0; rx_abort_evt = 0;
        tx_err_evt = 0; rx_err_evt = 0; tx_pkt_done = 0; tx_pkt_ok = 0; rx_good_evt = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) tick();
        // R1: reset state
        rd(0, rv); chk("R1 cause", rv, 8'h80);
        rd(1, rv); chk("R1 enable", rv, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();
        rd(0, rv); chk("R1 cause after release", rv, 8'h80);

        // R11: enable register storage, bit 7 reads 0
        wr(1, 8'hFF); rd(1, rv); chk("R11 enable ff", rv, 8'h7F);
        wr(1, 8'h2A); rd(1, rv); chk("R11 enable 2a", rv, 8'h2A);
        wr(1, 8'h00);

        // R2: write-one clear, write-zero keep
        wr(0, 8'hFF); rd(0, rv); chk("R2 clear all", rv, 8'h00);
        set_bit(0); set_bit(1);
        wr(0, 8'h00); rd(0, rv); chk("R2 zero write keeps", rv, 8'h03);
        wr(0, 8'h01); rd(0, rv); chk("R2 partial clear", rv, 8'h02);
        wr(0, 8'hFF);

        // R4 / R7 / R9 / R10 sweep: every bit against every enable value
        for (int b = 0; b < 7; b++) begin
            for (int m = 0; m < 128; m++) begin
                wr(0, 8'hFF);
                wr(1, m[7:0]);
                set_bit(b);
                rd(0, rv); chk($sformatf("R4 R7 cause bit %0d en %0h", b, m), rv, 8'(1 << b));
                chk($sformatf("R4 irq bit %0d en %0h", b, m), {7'b0, irq}, {7'b0, m[b]});
            end
        end

        // R5: halt sets stopped bit, never irq
        wr(0, 8'hFF); wr(1, 8'h7F);
        halt_evt = 1; tick(); halt_evt = 0;
        rd(0, rv); chk("R5 stopped set", rv, 8'h80);
        chk("R5 R4 stopped no irq", {7'b0, irq}, 8'h00);

        // R3: set and clear on the same edge, plus a clear of another bit
        wr(0, 8'hFF); set_bit(1);
        rx_good_evt = 1; wr(0, 8'h03); rx_good_evt = 0;
        rd(0, rv); chk("R3 set wins over clear", rv, 8'h01);

        // R7: failed completion outside chain mode
        wr(0, 8'hFF);
        tx_pkt_done = 1; tx_pkt_ok = 0; tick(); tx_pkt_done = 0;
        rd(0, rv); chk("R7 failed packet no ptx", rv, 8'h00);

        // R6: receive error with and without abort, with prior state
        for (int pre = 0; pre < 2; pre++) begin
            for (int c = 0; c < 4; c++) begin
                wr(0, 8'hFF);
                if (pre == 1) set_bit(2);
                rx_err_evt = c[0]; rx_abort_evt = c[1]; tick();
                rx_err_evt = 0; rx_abort_evt = 0;
                rd(0, rv);
                chk($sformatf("R6 pre %0d err %0d abort %0d", pre, c[0], c[1]), rv,
                    {3'b0, c[1], 1'b0, (pre == 1) || (c[0] && !c[1]), 2'b0});
            end
        end

        // R8: chain mode, all chain lengths 0..3 and all success patterns
        tx_chain_mode = 1;
        for (int n = 0; n < 4; n++) begin
            for (int p = 0; p < (1 << n); p++) begin
                wr(0, 8'hFF);
                for (int i = 0; i < n; i++) begin
                    tx_pkt_done = 1; tx_pkt_ok = p[i]; tick();
                    tx_pkt_done = 0; tx_pkt_ok = 0;
                end
                rd(0, rv); chk($sformatf("R8 mid chain n %0d p %0h", n, p), rv, 8'h00);
                tx_chain_end = 1; tick(); tx_chain_end = 0;
                rd(0, rv);
                chk($sformatf("R8 chain end n %0d p %0h", n, p), rv,
                    {6'b0, (p != 0) || (n == 0), 1'b0});
            end
        end
        // R8: success coinciding with chain end after a failure
        wr(0, 8'hFF);
        tx_pkt_done = 1; tx_pkt_ok = 0; tick();
        tx_pkt_ok = 1; tx_chain_end = 1; tick();
        tx_pkt_done = 0; tx_pkt_ok = 0; tx_chain_end = 0;
        rd(0, rv); chk("R8 success on end cycle", rv, 8'h02);
        // R8: failure coinciding with chain end is a non-empty failed chain
        wr(0, 8'hFF);
        tx_pkt_done = 1; tx_pkt_ok = 0; tx_chain_end = 1; tick();
        tx_pkt_done = 0; tx_chain_end = 0;
        rd(0, rv); chk("R8 failure on end cycle", rv, 8'h00);
        tx_chain_mode = 0;

        // R9: boundary and once-per-crossing
        wr(0, 8'hFF);
        rx_in_frame = 1; rx_byte_cnt = LIMIT; tick();
        rd(0, rv); chk("R9 equal no warning", rv, 8'h00);
        rx_byte_cnt = LIMIT + 1; tick();
        rd(0, rv); chk("R9 crossing warns", rv, 8'h40);
        rx_byte_cnt = LIMIT + 2; wr(0, 8'h40); tick();
        rd(0, rv); chk("R9 no repeat in frame", rv, 8'h00);
        rx_in_frame = 0; rx_byte_cnt = '0; tick();
        rd(0, rv); chk("R9 out of frame", rv, 8'h00);

        // R10: rising MSB only
        err_cnt_msb = 3'b100; tick();
        rd(0, rv); chk("R10 msb rise", rv, 8'h20);
        wr(0, 8'h20); tick();
        rd(0, rv); chk("R10 held msb no repeat", rv, 8'h00);
        err_cnt_msb = 3'b110; tick();
        rd(0, rv); chk("R10 second counter rise", rv, 8'h20);
        err_cnt_msb = '0; tick();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule